// File: doc/BRIEF.md
# Load/Store Dispatch Ordering Unit

This block sits at the dispatch point of an out-of-order core's memory pipeline. Each cycle it may receive one operation, tagged as a non-memory operation, load, store, load barrier, store barrier or full barrier. It reports whether the load queue and the store queue have room for that operation. When the operation is accepted, the block takes the queue entries it needs and gives it a memory-group number. Operations in one group carry no ordering among themselves. An ordering edge from an older group to the new one is issued whenever the weak consistency model requires it.

The group number and up to two predecessor group numbers are presented in the same cycle as the dispatch. A downstream group tracker uses them to decide when each group may issue. Queue entries are returned by one-cycle release pulses: load entries at retirement and store entries at commit. A single configuration input lets loads run ahead of older stores, for use when loads and stores are known not to alias. Barriers order loads or stores without draining the queues.

Top module: `mem_order_dispatch`

## Requirements
- R1: `disp_status` is 0 when the operation fits, 1 when it needs a load entry and the load queue is full, and 2 when it needs a store entry and the store queue is full. The load check wins when both fail. A queue whose size parameter is 0 never reports full. Otherwise a queue is full when its used count equals its size.
- R2: Kind 0 (not a memory operation) always sees status 0. It is accepted with group number 0, `grp_new` low and both predecessor numbers 0, and it changes no count.
- R3: A dispatch is accepted only in a cycle whose status is 0. A dispatch attempted at status 1 or 2 is dropped, allocates nothing, and sets `err_flag`, which then stays set until reset.
- R4: Each accepted operation takes exactly one entry in each queue it uses. Kind 1 (load) and kind 3 (load barrier) use the load queue. Kind 2 (store) and kind 4 (store barrier) use the store queue. Kind 5 (full barrier) uses one entry in each queue. A release pulse and a dispatch in the same cycle are both applied to the count.
- R5: A load (kind 1) that follows a load which opened a group, with no store or barrier dispatched in between, joins that group. It reports the same group number, `grp_new` low and no predecessors.
- R6: A load that opens a new group takes the current store group as `dep_st_id` when `cfg_no_alias` is 0. It takes 0 when `cfg_no_alias` is 1. Any store-queue operation closes the open load group.
- R7: Every store, store barrier and full barrier opens a new group. Its `dep_ld_id` is the current load group and its `dep_st_id` is the current store group. It then becomes the current store group.
- R8: A load barrier opens a new group with `dep_ld_id` equal to the current load group. Every later load group takes it as `dep_ld_id` until another load-side barrier replaces it.
- R9: A full barrier becomes the current load, load-barrier and store group at once.
- R10: Group numbers start at 1 after reset and increase by one per new group. After the largest value they wrap to 1, never producing 0.
- R11: A release pulse on an empty queue is ignored and the count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_no_alias | input | 1 | 1 lets loads run ahead of older stores |
| disp_valid | input | 1 | A dispatch is presented this cycle |
| disp_kind | input | 3 | Operation kind (0 none, 1 load, 2 store, 3 load barrier, 4 store barrier, 5 full barrier) |
| ld_release | input | 1 | Return one load-queue entry |
| st_release | input | 1 | Return one store-queue entry |
| disp_status | output | 2 | Availability status for the presented kind |
| disp_accept | output | 1 | Dispatch is taken this cycle |
| grp_id | output | ID_W | Group number given to the operation |
| grp_new | output | 1 | The group number is freshly opened |
| dep_ld_id | output | ID_W | Load-side predecessor group (0 none) |
| dep_st_id | output | ID_W | Store-side predecessor group (0 none) |
| ld_used | output | CNT_W | Load-queue entries in use |
| st_used | output | CNT_W | Store-queue entries in use |
| err_flag | output | 1 | Sticky: a dispatch was attempted while blocked |

## Verification
Several properties are checked on every cycle. Acceptance only under status 0, no illegal status code, no allocation into a full queue, stickiness of the error flag, non-zero group numbers for new groups and a fresh group for every store-side operation all belong to this set. The predecessor numbers, the joining of loads into an open group, the effect of the no-alias input, barrier chaining and the wrap of the group counter depend on the history of dispatches. Only the bench's directed sequences show these, by comparing each dispatch's outputs with values worked out from the ordering rules.

// File: rtl/mod_pkg.sv
package mod_pkg;

  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_LOAD  = 3'd1,
    KIND_STORE = 3'd2,
    KIND_LDBAR = 3'd3,
    KIND_STBAR = 3'd4,
    KIND_FULL  = 3'd5
  } mem_kind_e;

  typedef enum logic [1:0] {
    ST_AVAIL   = 2'd0,
    ST_LQ_FULL = 2'd1,
    ST_SQ_FULL = 2'd2
  } avail_e;

  function automatic logic uses_lq(input mem_kind_e k);
    return (k == KIND_LOAD) || (k == KIND_LDBAR) || (k == KIND_FULL);
  endfunction

  function automatic logic uses_sq(input mem_kind_e k);
    return (k == KIND_STORE) || (k == KIND_STBAR) || (k == KIND_FULL);
  endfunction

  function automatic avail_e pick_status(input mem_kind_e k, input logic lq_full,
                                         input logic sq_full);
    if (uses_lq(k) && lq_full) return ST_LQ_FULL;
    if (uses_sq(k) && sq_full) return ST_SQ_FULL;
    return ST_AVAIL;
  endfunction

endpackage

// File: rtl/mod_queue_count.sv
module mod_queue_count #(
  parameter int SIZE  = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             give_back,
  output logic [CNT_W-1:0] used,
  output logic             full
);
  logic [CNT_W-1:0] used_q;
  logic             drop_one;

  assign drop_one = give_back && (used_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_q + CNT_W'(take) - CNT_W'(drop_one);
  end

  generate
    if (SIZE == 0) begin : g_unbounded
      assign full = 1'b0;
    end else begin : g_bounded
      localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SIZE);
      assign full = (used_q == LIMIT);
    end
  endgenerate

  assign used = used_q;

  // R4: no entry is taken from a full queue
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !take);

  // R11: a release on an empty queue leaves it empty
  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q == '0 && !take) |=> (used_q == '0));

endmodule

// File: rtl/mod_group_alloc.sv
module mod_group_alloc
  import mod_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  mem_kind_e       kind,
  input  logic            no_alias,
  output logic [ID_W-1:0] gid,
  output logic            gid_new,
  output logic [ID_W-1:0] dep_ld,
  output logic [ID_W-1:0] dep_st
);
  localparam logic [ID_W-1:0] ID_MAX = '1;
  localparam logic [ID_W-1:0] ID_ONE = ID_W'(1);

  function automatic logic [ID_W-1:0] bump_id(input logic [ID_W-1:0] id);
    return (id == ID_MAX) ? ID_ONE : id + ID_ONE;
  endfunction

  logic [ID_W-1:0] cur_ld, cur_lb, cur_st, next_id;
  logic [ID_W-1:0] nx_ld, nx_lb, nx_st, nx_id;
  logic            ld_open, nx_open;

  always_comb begin
    gid     = '0;
    gid_new = 1'b0;
    dep_ld  = '0;
    dep_st  = '0;
    nx_ld   = cur_ld;
    nx_lb   = cur_lb;
    nx_st   = cur_st;
    nx_open = ld_open;
    nx_id   = next_id;
    if (accept) begin
      case (kind)
        KIND_LOAD, KIND_LDBAR: begin
          if (kind == KIND_LOAD && ld_open) begin
            gid = cur_ld;
          end else begin
            gid     = next_id;
            gid_new = 1'b1;
            dep_ld  = (kind == KIND_LOAD) ? cur_lb : cur_ld;
            dep_st  = no_alias ? '0 : cur_st;
            nx_ld   = next_id;
            if (kind == KIND_LDBAR) nx_lb = next_id;
            nx_open = (kind == KIND_LOAD);
            nx_id   = bump_id(next_id);
          end
        end
        KIND_STORE, KIND_STBAR, KIND_FULL: begin
          gid     = next_id;
          gid_new = 1'b1;
          dep_ld  = cur_ld;
          dep_st  = cur_st;
          nx_st   = next_id;
          nx_open = 1'b0;
          if (kind == KIND_FULL) begin
            nx_ld = next_id;
            nx_lb = next_id;
          end
          nx_id   = bump_id(next_id);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ld  <= '0;
      cur_lb  <= '0;
      cur_st  <= '0;
      ld_open <= 1'b0;
      next_id <= ID_ONE;
    end else begin
      cur_ld  <= nx_ld;
      cur_lb  <= nx_lb;
      cur_st  <= nx_st;
      ld_open <= nx_open;
      next_id <= nx_id;
    end
  end

  // R10: the allocation counter never holds the reserved value 0
  assert_id_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    next_id != '0);

  // R10: opening a group moves the counter on
  assert_id_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gid_new |=> (next_id != $past(next_id)));

  // R5: a joining load reports no predecessors
  assert_join_nodeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !gid_new) |-> (dep_ld == '0 && dep_st == '0));

endmodule

// File: rtl/mem_order_dispatch.sv
module mem_order_dispatch
  import mod_pkg::*;
#(
  parameter int LQ_SIZE = 4,
  parameter int SQ_SIZE = 2,
  parameter int ID_W    = 3,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_no_alias,
  input  logic             disp_valid,
  input  logic [2:0]       disp_kind,
  input  logic             ld_release,
  input  logic             st_release,
  output logic [1:0]       disp_status,
  output logic             disp_accept,
  output logic [ID_W-1:0]  grp_id,
  output logic             grp_new,
  output logic [ID_W-1:0]  dep_ld_id,
  output logic [ID_W-1:0]  dep_st_id,
  output logic [CNT_W-1:0] ld_used,
  output logic [CNT_W-1:0] st_used,
  output logic             err_flag
);
  mem_kind_e kind;
  avail_e    status;
  logic      lq_full, sq_full;
  logic      take_lq, take_sq, blocked_try;
  logic      err_q;

  assign kind        = mem_kind_e'(disp_kind);
  assign status      = pick_status(kind, lq_full, sq_full);
  assign disp_status = status;
  assign disp_accept = disp_valid && (status == ST_AVAIL);
  assign blocked_try = disp_valid && (status != ST_AVAIL);
  assign take_lq     = disp_accept && uses_lq(kind);
  assign take_sq     = disp_accept && uses_sq(kind);

  mod_queue_count #(.SIZE(LQ_SIZE), .CNT_W(CNT_W)) i_lq (
    .clk(clk), .rst_n(rst_n), .take(take_lq), .give_back(ld_release),
    .used(ld_used), .full(lq_full)
  );

  mod_queue_count #(.SIZE(SQ_SIZE), .CNT_W(CNT_W)) i_sq (
    .clk(clk), .rst_n(rst_n), .take(take_sq), .give_back(st_release),
    .used(st_used), .full(sq_full)
  );

  mod_group_alloc #(.ID_W(ID_W)) i_alloc (
    .clk(clk), .rst_n(rst_n), .accept(disp_accept), .kind(kind),
    .no_alias(cfg_no_alias), .gid(grp_id), .gid_new(grp_new),
    .dep_ld(dep_ld_id), .dep_st(dep_st_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           err_q <= 1'b0;
    else if (blocked_try) err_q <= 1'b1;
  end
  assign err_flag = err_q;

  // R1: only the three defined status codes appear
  assert_status_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    disp_status != 2'd3);

  // R3: acceptance only with the available status
  assert_accept_avail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_accept |-> (disp_status == 2'd0));

  // R3: the error flag holds once set
  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R2: a non-memory operation is given no group
  assert_nomem_nogroup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_accept && disp_kind == 3'd0) |-> (grp_id == '0 && !grp_new));

  // R7: store-side operations always open a group
  assert_store_fresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_accept && uses_sq(kind)) |-> grp_new);

  // R10: a freshly opened group never carries number 0
  assert_new_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grp_new |-> (grp_id != '0));

endmodule

// File: tb/test_mem_order_dispatch.sv
module test_mem_order_dispatch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_no_alias = 1'b0;
  logic       disp_valid = 1'b0;
  logic [2:0] disp_kind = 3'd0;
  logic       ld_release = 1'b0;
  logic       st_release = 1'b0;
  logic [1:0] disp_status;
  logic       disp_accept, grp_new, err_flag;
  logic [2:0] grp_id, dep_ld_id, dep_st_id;
  logic [3:0] ld_used, st_used;

  logic       u_valid = 1'b0;
  logic [1:0] u_status;
  logic       u_accept, u_new, u_err;
  logic [2:0] u_gid, u_dl, u_ds;
  logic [3:0] u_ld, u_st;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mem_order_dispatch i_mem_order_dispatch (
    .clk(clk), .rst_n(rst_n), .cfg_no_alias(cfg_no_alias),
    .disp_valid(disp_valid), .disp_kind(disp_kind),
    .ld_release(ld_release), .st_release(st_release),
    .disp_status(disp_status), .disp_accept(disp_accept), .grp_id(grp_id),
    .grp_new(grp_new), .dep_ld_id(dep_ld_id), .dep_st_id(dep_st_id),
    .ld_used(ld_used), .st_used(st_used), .err_flag(err_flag)
  );

  mem_order_dispatch #(.LQ_SIZE(0), .SQ_SIZE(0)) i_mem_order_dispatch_unb (
    .clk(clk), .rst_n(rst_n), .cfg_no_alias(1'b0),
    .disp_valid(u_valid), .disp_kind(3'd1),
    .ld_release(1'b0), .st_release(1'b0),
    .disp_status(u_status), .disp_accept(u_accept), .grp_id(u_gid),
    .grp_new(u_new), .dep_ld_id(u_dl), .dep_st_id(u_ds),
    .ld_used(u_ld), .st_used(u_st), .err_flag(u_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Present one dispatch, compare combinational outputs, then let it commit.
  task automatic disp(input string req, input int kind, input int st, input int acc,
                      input int gid, input int nw, input int dl, input int ds);
    @(negedge clk);
    disp_valid = 1'b1;
    disp_kind  = 3'(kind);
    #1;
    chk(req, "status", int'(disp_status), st);
    chk(req, "accept", int'(disp_accept), acc);
    if (acc != 0) begin
      chk(req, "grp_id", int'(grp_id), gid);
      chk(req, "grp_new", int'(grp_new), nw);
      chk(req, "dep_ld", int'(dep_ld_id), dl);
      chk(req, "dep_st", int'(dep_st_id), ds);
    end
    @(posedge clk);
    #1;
    disp_valid = 1'b0;
    disp_kind  = 3'd0;
  endtask

  task automatic release_q(input int lds, input int sts);
    @(negedge clk);
    ld_release = (lds != 0);
    st_release = (sts != 0);
    @(posedge clk);
    #1;
    ld_release = 1'b0;
    st_release = 1'b0;
  endtask

  task automatic counts(input string req, input int lq, input int sq);
    @(negedge clk);
    chk(req, "ld_used", int'(ld_used), lq);
    chk(req, "st_used", int'(st_used), sq);
  endtask

  task automatic t_reset;
    @(negedge clk);
    disp_kind = 3'd1;
    #1;
    chk("R1", "reset status", int'(disp_status), 0);
    chk("R3", "reset err", int'(err_flag), 0);
    disp_kind = 3'd0;
    counts("R4", 0, 0);
  endtask

  task automatic t_loads_join;
    disp("R5", 1, 0, 1, 1, 1, 0, 0);
    disp("R5", 1, 0, 1, 1, 0, 0, 0);
    counts("R4", 2, 0);
  endtask

  task automatic t_stores;
    disp("R7", 2, 0, 1, 2, 1, 1, 0);
    disp("R7", 2, 0, 1, 3, 1, 1, 2);
    counts("R4", 2, 2);
    disp("R1", 2, 2, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R3", "err after blocked store", int'(err_flag), 1);
    counts("R3", 2, 2);
  endtask

  task automatic t_load_after_store;
    disp("R6", 1, 0, 1, 4, 1, 0, 3);
    release_q(0, 1);
    counts("R4", 3, 1);
    @(negedge clk);
    st_release = 1'b1;
    disp("R4", 2, 0, 1, 5, 1, 4, 3);
    st_release = 1'b0;
    counts("R4", 3, 1);
  endtask

  task automatic t_no_alias;
    cfg_no_alias = 1'b1;
    disp("R6", 1, 0, 1, 6, 1, 0, 0);
    counts("R4", 4, 1);
    disp("R1", 1, 1, 0, 0, 0, 0, 0);
    counts("R3", 4, 1);
    chk("R3", "err stays", int'(err_flag), 1);
    cfg_no_alias = 1'b0;
    release_q(1, 0);
    release_q(1, 0);
    counts("R4", 2, 1);
  endtask

  task automatic t_load_barrier;
    disp("R8", 3, 0, 1, 7, 1, 6, 5);
    disp("R10", 1, 0, 1, 1, 1, 7, 5);
    counts("R8", 4, 1);
    release_q(1, 0);
    release_q(1, 0);
  endtask

  task automatic t_full_barrier;
    disp("R9", 5, 0, 1, 2, 1, 1, 5);
    counts("R4", 3, 2);
    disp("R9", 1, 0, 1, 3, 1, 2, 2);
    disp("R1", 2, 2, 0, 0, 0, 0, 0);
    disp("R1", 5, 1, 0, 0, 0, 0, 0);
    release_q(0, 1);
    disp("R9", 2, 0, 1, 4, 1, 3, 2);
    counts("R9", 4, 2);
  endtask

  task automatic t_non_mem;
    disp("R2", 0, 0, 1, 0, 0, 0, 0);
    counts("R2", 4, 2);
  endtask

  task automatic t_drain;
    for (int i = 0; i < 5; i++) release_q(1, 0);
    for (int i = 0; i < 3; i++) release_q(0, 1);
    counts("R11", 0, 0);
  endtask

  task automatic t_unbounded;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      u_valid = 1'b1;
      #1;
      chk("R1", "unbounded status", int'(u_status), 0);
      @(posedge clk);
      #1;
      u_valid = 1'b0;
    end
    @(negedge clk);
    chk("R1", "unbounded used", int'(u_ld), 5);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_loads_join();
    t_stores();
    t_load_after_store();
    t_no_alias();
    t_load_barrier();
    t_full_barrier();
    t_non_mem();
    t_drain();
    t_unbounded();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule